// File: doc/BRIEF.md
# Indexed Interrupt Routing Register File

This block is the configuration store for an interrupt router. Software reaches it through a narrow two-offset window. A write to the select offset stores an 8-bit index. An access to the data offset then reads or writes the internal 32-bit register that the index names. The internal registers are a unit identity, a read-only version word, an arbitration identity, and a table of 64-bit routing entries. Each entry covers two consecutive indices, one per 32-bit half.

The decoded fields of every entry drive the routing logic in parallel: mask, vector, delivery mode, logical/physical destination mode, polarity, trigger mode and destination. The unit and arbitration identities are also brought out as ports.

Requests arrive on a valid/ready channel and responses leave on a valid/ready channel. A request is accepted only when the one-deep response slot is empty or is being drained in the same cycle. Writes take effect at the accepting clock edge. The response carries read data, or zero for a write, together with an error flag.

Top module: `irq_route_regs`

## Requirements
- R1: Byte offset 0x00 reads and writes the select register. A legal write stores wdata[7:0]. A read returns the select value in bits 7:0 with bits 31:8 zero. Offset 0x10 is the data window for the register that the current select value names.
- R2: An access is legal only if req_addr is 0x00 or 0x10 and req_strb is 4'b1111. An illegal access returns rsp_err=1 and rsp_rdata=0, and it changes no state.
- R3: req_ready is high exactly when rsp_valid is low or rsp_ready is high. The response appears in the cycle after acceptance. While rsp_valid is high and rsp_ready is low, rsp_rdata and rsp_err hold steady.
- R4: Index 0x00 is the unit identity. A write stores wdata[31:24]. A read returns {id, 24'h0}. The stored value drives unit_id.
- R5: Index 0x01 reads {8'h00, N-1, 8'h00, VER} and ignores writes.
- R6: Index 0x02 is the arbitration identity, in the same format as R4. It drives arb_id.
- R7: Entry i has its low half at index 0x10+2i and its high half at index 0x11+2i. Low-half bits: vector 7:0, delivery mode 10:8, logical destination 11, active-low polarity 13, level trigger 15, mask 16. High-half bits: destination 31:24. These fields appear on the ent_* ports.
- R8: A write to a low half keeps only the bits in 32'h0001_AFFF. A write to a high half keeps only the bits in 32'hFF00_0000. All other bits read back as zero.
- R9: After reset, every low half reads 32'h0001_0000 and every high half reads 0. unit_id and arb_id equal INIT_ID, and the select register is 0.
- R10: Indices 0x03 to 0x0F, and indices from 0x10+2N upward, read as zero. A write to one of them has no effect and returns rsp_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high together with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (5) | Byte offset within the window |
| req_strb | input | 4 | Byte enables; all four must be set |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Illegal offset or width |
| unit_id | output | 8 | Unit identity |
| arb_id | output | 8 | Arbitration identity |
| ent_mask | output | N | Per-entry mask |
| ent_vector | output | 8*N | Per-entry vector, entry i at [8i+7:8i] |
| ent_mode | output | 3*N | Per-entry delivery mode |
| ent_logical | output | N | Per-entry logical destination mode |
| ent_low_active | output | N | Per-entry active-low polarity |
| ent_level | output | N | Per-entry level trigger |
| ent_dest | output | 8*N | Per-entry destination |

## Verification
The bench builds the block with N=6, VER=0x11 and INIT_ID=0x5A. Because the table is small, every entry half can be written and read back in a short run. The first index past the table (0x1C) and the top index 0xFF also become cheap to reach as undefined registers. The non-zero initial identity makes the reset value of both identity registers visible.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
  localparam logic [7:0]  IDX_UNIT = 8'h00;
  localparam logic [7:0]  IDX_VER  = 8'h01;
  localparam logic [7:0]  IDX_ARB  = 8'h02;
  localparam int unsigned TBL_BASE = 16;
  localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
  localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
  localparam logic [31:0] LO_RST   = 32'h0001_0000;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       low_active;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } route_t;

  function automatic route_t unpack_entry(input logic [31:0] lo, input logic [31:0] hi);
    route_t r;
    r.vector     = lo[7:0];
    r.mode       = lo[10:8];
    r.logical    = lo[11];
    r.low_active = lo[13];
    r.level      = lo[15];
    r.mask       = lo[16];
    r.dest       = hi[31:24];
    return r;
  endfunction
endpackage

// File: rtl/irq_bus_front.sv
module irq_bus_front #(
  parameter int ADDR_W  = 5,
  parameter int SEL_OFF = 0,
  parameter int WIN_OFF = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_strb,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [7:0]        sel_q,
  output logic              win_we,
  output logic [31:0]       win_wdata,
  input  logic [31:0]       win_rdata
);
  localparam logic [ADDR_W-1:0] SEL_A = SEL_OFF[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] WIN_A = WIN_OFF[ADDR_W-1:0];

  logic accept, hit_sel, hit_win, full, legal;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign hit_sel   = (req_addr == SEL_A);
  assign hit_win   = (req_addr == WIN_A);
  assign full      = &req_strb;
  assign legal     = (hit_sel || hit_win) && full;
  assign win_we    = accept && req_write && hit_win && full;
  assign win_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (accept && req_write && hit_sel && full) begin
      sel_q <= req_wdata[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= !legal;
      if (!legal || req_write) rsp_rdata <= '0;
      else if (hit_sel)        rsp_rdata <= {24'h0, sel_q};
      else                     rsp_rdata <= win_rdata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ident_regs.sv
module irq_ident_regs
  import irq_regs_pkg::*;
#(
  parameter int         N       = 24,
  parameter logic [7:0] VER     = 8'h11,
  parameter logic [7:0] INIT_ID = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  sel,
  input  logic        win_we,
  input  logic [31:0] win_wdata,
  output logic [7:0]  unit_id,
  output logic [7:0]  arb_id,
  output logic [31:0] rd_data
);
  localparam logic [7:0]  TOP_IDX  = 8'(N - 1);
  localparam logic [31:0] VER_WORD = {8'h00, TOP_IDX, 8'h00, VER};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_id <= INIT_ID;
      arb_id  <= INIT_ID;
    end else if (win_we) begin
      if (sel == IDX_UNIT) unit_id <= win_wdata[31:24];
      if (sel == IDX_ARB)  arb_id  <= win_wdata[31:24];
    end
  end

  always_comb begin
    unique case (sel)
      IDX_UNIT: rd_data = {unit_id, 24'h0};
      IDX_VER:  rd_data = VER_WORD;
      IDX_ARB:  rd_data = {arb_id, 24'h0};
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_regs_pkg::*;
#(
  parameter int N = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          sel,
  input  logic                win_we,
  input  logic [31:0]         win_wdata,
  output logic [N-1:0][31:0]  lo_q,
  output logic [N-1:0][31:0]  hi_q,
  output logic [31:0]         rd_data
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam logic [7:0] LO_IDX = 8'(TBL_BASE + 2 * i);
    localparam logic [7:0] HI_IDX = 8'(TBL_BASE + 2 * i + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= LO_RST;
        hi_q[i] <= '0;
      end else if (win_we) begin
        if (sel == LO_IDX) lo_q[i] <= win_wdata & LO_KEEP;
        if (sel == HI_IDX) hi_q[i] <= win_wdata & HI_KEEP;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (sel == 8'(TBL_BASE + 2 * i))     rd_data = rd_data | lo_q[i];
      if (sel == 8'(TBL_BASE + 2 * i + 1)) rd_data = rd_data | hi_q[i];
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_regs_pkg::*;
#(
  parameter int         N       = 24,
  parameter logic [7:0] VER     = 8'h11,
  parameter logic [7:0] INIT_ID = 8'h00,
  parameter int         ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_strb,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [7:0]        unit_id,
  output logic [7:0]        arb_id,
  output logic [N-1:0]      ent_mask,
  output logic [8*N-1:0]    ent_vector,
  output logic [3*N-1:0]    ent_mode,
  output logic [N-1:0]      ent_logical,
  output logic [N-1:0]      ent_low_active,
  output logic [N-1:0]      ent_level,
  output logic [8*N-1:0]    ent_dest
);
  logic [7:0]          sel_q;
  logic                win_we;
  logic [31:0]         win_wdata, win_rdata, id_rd, tbl_rd;
  logic [N-1:0][31:0]  lo_q, hi_q;

  irq_bus_front #(.ADDR_W(ADDR_W), .SEL_OFF(0), .WIN_OFF(16)) u_front (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_strb(req_strb), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .sel_q(sel_q), .win_we(win_we),
    .win_wdata(win_wdata), .win_rdata(win_rdata)
  );

  irq_ident_regs #(.N(N), .VER(VER), .INIT_ID(INIT_ID)) u_ident (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .win_we(win_we),
    .win_wdata(win_wdata), .unit_id(unit_id), .arb_id(arb_id),
    .rd_data(id_rd)
  );

  irq_redir_table #(.N(N)) u_table (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .win_we(win_we),
    .win_wdata(win_wdata), .lo_q(lo_q), .hi_q(hi_q), .rd_data(tbl_rd)
  );

  // The two read sources never hit the same index, so an OR merges them.
  assign win_rdata = id_rd | tbl_rd;

  for (genvar i = 0; i < N; i++) begin : g_out
    route_t r;
    assign r = unpack_entry(lo_q[i], hi_q[i]);
    assign ent_mask[i]          = r.mask;
    assign ent_vector[8*i +: 8] = r.vector;
    assign ent_mode[3*i +: 3]   = r.mode;
    assign ent_logical[i]       = r.logical;
    assign ent_low_active[i]    = r.low_active;
    assign ent_level[i]         = r.level;
    assign ent_dest[8*i +: 8]   = r.dest;
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
  parameter int         N      = 24,
  parameter logic [7:0] VER    = 8'h11,
  parameter int         ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [3:0]        req_strb,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic [7:0]        sel_q
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(N - 1), 8'h00, VER};
  logic acc, ok, rd_win, rd_sel;
  assign acc    = req_valid && req_ready;
  assign ok     = (req_addr == 5'h00 || req_addr == 5'h10) && req_strb == 4'hF;
  assign rd_win = acc && ok && !req_write && req_addr == 5'h10;
  assign rd_sel = acc && ok && !req_write && req_addr == 5'h00;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)); // R3
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R3
  AST_BAD_ACCESS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ok |=> rsp_valid && rsp_err && rsp_rdata == 32'h0); // R2
  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win && sel_q == 8'h01 |=> rsp_rdata == VER_WORD && !rsp_err); // R5
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_win && sel_q >= 8'h03 && sel_q < 8'h10 |=> rsp_rdata == 32'h0); // R10
  AST_SEL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> rsp_rdata == {24'h0, $past(sel_q)}); // R1
endmodule

bind irq_route_regs irq_route_regs_chk #(.N(N), .VER(VER), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_route_regs_test.sv
module irq_route_regs_test;
  localparam int         N       = 6;
  localparam logic [7:0] VER     = 8'h11;
  localparam logic [7:0] INIT_ID = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [4:0]  req_addr = '0;
  logic [3:0]  req_strb = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [7:0] unit_id, arb_id;
  logic [N-1:0] ent_mask, ent_logical, ent_low_active, ent_level;
  logic [8*N-1:0] ent_vector, ent_dest;
  logic [3*N-1:0] ent_mode;

  always #2 clk = ~clk;

  irq_route_regs #(.N(N), .VER(VER), .INIT_ID(INIT_ID), .ADDR_W(5)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_strb(req_strb),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .unit_id(unit_id), .arb_id(arb_id),
    .ent_mask(ent_mask), .ent_vector(ent_vector), .ent_mode(ent_mode),
    .ent_logical(ent_logical), .ent_low_active(ent_low_active),
    .ent_level(ent_level), .ent_dest(ent_dest)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_lo [N];
  logic [31:0] m_hi [N];
  logic [7:0]  m_sel, m_id, m_arb;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [7:0] idx);
    int k;
    k = int'(idx);
    if (k == 0) return {m_id, 24'h0};
    if (k == 1) return {8'h00, 8'(N - 1), 8'h00, VER};
    if (k == 2) return {m_arb, 24'h0};
    if (k >= 16 && k < 16 + 2 * N) return (k % 2) ? m_hi[(k - 16) / 2] : m_lo[(k - 16) / 2];
    return 32'h0;
  endfunction

  task automatic m_write(input logic [7:0] idx, input logic [31:0] d);
    int k;
    k = int'(idx);
    if (k == 0) m_id = d[31:24];
    else if (k == 2) m_arb = d[31:24];
    else if (k >= 16 && k < 16 + 2 * N) begin
      if (k % 2) m_hi[(k - 16) / 2] = d & 32'hFF00_0000;
      else       m_lo[(k - 16) / 2] = d & 32'h0001_AFFF;
    end
  endtask

  // one transaction, response checked against the model
  task automatic access(input bit we, input logic [4:0] a, input logic [3:0] s,
                        input logic [31:0] d, input string tag, output logic [31:0] got);
    logic legal;
    logic [31:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_strb = s; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    legal = (a == 5'h00 || a == 5'h10) && s == 4'hF;
    if (!legal || we) exp = 32'h0;
    else if (a == 5'h00) exp = {24'h0, m_sel};
    else exp = m_read(m_sel);
    if (legal && we) begin
      if (a == 5'h00) m_sel = d[7:0];
      else m_write(m_sel, d);
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
    chk({tag, " rsp_err"}, {31'h0, rsp_err}, {31'h0, !legal});
    chk({tag, " rsp_rdata"}, rsp_rdata, exp);
    got = rsp_rdata;
  endtask

  // every-cycle comparison of the routing outputs with the model (R4 R6 R7)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        chk("R7 ent fields",
            {8'h0, ent_dest[8*i +: 8], ent_vector[8*i +: 8], 2'b0, ent_mask[i], ent_level[i],
             ent_low_active[i], ent_logical[i], ent_mode[3*i +: 3]},
            {8'h0, m_hi[i][31:24], m_lo[i][7:0], 2'b0, m_lo[i][16], m_lo[i][15],
             m_lo[i][13], m_lo[i][11], m_lo[i][10:8]});
      end
      chk("R4 unit_id", {24'h0, unit_id}, {24'h0, m_id});
      chk("R6 arb_id", {24'h0, arb_id}, {24'h0, m_arb});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] g, held;
    for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0; end
    m_sel = 8'h00; m_id = INIT_ID; m_arb = INIT_ID;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    access(0, 5'h00, 4'hF, 0, "R9 select reset", g);
    chk("R9 select is zero", g, 32'h0);
    access(0, 5'h10, 4'hF, 0, "R9 id reset", g);
    chk("R9 id init", g, {INIT_ID, 24'h0});
    access(1, 5'h00, 4'hF, 32'h2, "R9 sel arb", g);
    access(0, 5'h10, 4'hF, 0, "R9 arb reset", g);
    chk("R9 arb init", g, {INIT_ID, 24'h0});
    for (int i = 0; i < N; i++) begin
      access(1, 5'h00, 4'hF, 32'(16 + 2 * i), "R9 sel lo", g);
      access(0, 5'h10, 4'hF, 0, "R9 lo reset", g);
      chk("R9 lo reset value", g, 32'h0001_0000);
      access(1, 5'h00, 4'hF, 32'(17 + 2 * i), "R9 sel hi", g);
      access(0, 5'h10, 4'hF, 0, "R9 hi reset", g);
      chk("R9 hi reset value", g, 32'h0);
    end

    // R1 select keeps only low byte
    access(1, 5'h00, 4'hF, 32'hABCD_12C3, "R1 sel write", g);
    access(0, 5'h00, 4'hF, 0, "R1 sel read", g);
    chk("R1 sel low byte", g, 32'h0000_00C3);

    // R4 identity
    access(1, 5'h00, 4'hF, 32'h0, "R4 sel", g);
    access(1, 5'h10, 4'hF, 32'hABCD_EF12, "R4 write", g);
    access(0, 5'h10, 4'hF, 0, "R4 read", g);
    chk("R4 id field", g, 32'hAB00_0000);

    // R6 arbitration
    access(1, 5'h00, 4'hF, 32'h2, "R6 sel", g);
    access(1, 5'h10, 4'hF, 32'h3C00_FFFF, "R6 write", g);
    access(0, 5'h10, 4'hF, 0, "R6 read", g);
    chk("R6 arb field", g, 32'h3C00_0000);

    // R5 version, write ignored
    access(1, 5'h00, 4'hF, 32'h1, "R5 sel", g);
    access(0, 5'h10, 4'hF, 0, "R5 read", g);
    chk("R5 version word", g, 32'h0005_0011);
    access(1, 5'h10, 4'hF, 32'hFFFF_FFFF, "R5 write", g);
    access(0, 5'h10, 4'hF, 0, "R5 reread", g);
    chk("R5 version unchanged", g, 32'h0005_0011);

    // R8 reserved clearing, explicit constants
    access(1, 5'h00, 4'hF, 32'h10, "R8 sel lo0", g);
    access(1, 5'h10, 4'hF, 32'hFFFF_FFFF, "R8 write lo", g);
    access(0, 5'h10, 4'hF, 0, "R8 read lo", g);
    chk("R8 lo keep mask", g, 32'h0001_AFFF);
    access(1, 5'h00, 4'hF, 32'h11, "R8 sel hi0", g);
    access(1, 5'h10, 4'hF, 32'hFFFF_FFFF, "R8 write hi", g);
    access(0, 5'h10, 4'hF, 0, "R8 read hi", g);
    chk("R8 hi keep mask", g, 32'hFF00_0000);

    // R7 every entry with its own pattern, checked through outputs and reads
    for (int i = 0; i < N; i++) begin
      access(1, 5'h00, 4'hF, 32'(16 + 2 * i), "R7 sel lo", g);
      access(1, 5'h10, 4'hF, 32'h0000_5A00 ^ (32'h0001_2345 * (i + 1)), "R7 write lo", g);
      access(0, 5'h10, 4'hF, 0, "R7 read lo", g);
      access(1, 5'h00, 4'hF, 32'(17 + 2 * i), "R7 sel hi", g);
      access(1, 5'h10, 4'hF, 32'h1357_9BDF * (i + 3), "R7 write hi", g);
      access(0, 5'h10, 4'hF, 0, "R7 read hi", g);
    end

    // R10 undefined indices
    access(1, 5'h00, 4'hF, 32'h05, "R10 sel 05", g);
    access(1, 5'h10, 4'hF, 32'hFFFF_FFFF, "R10 write 05", g);
    access(0, 5'h10, 4'hF, 0, "R10 read 05", g);
    chk("R10 index 05 zero", g, 32'h0);
    access(1, 5'h00, 4'hF, 32'h1C, "R10 sel past table", g);
    access(1, 5'h10, 4'hF, 32'hFFFF_FFFF, "R10 write past table", g);
    access(0, 5'h10, 4'hF, 0, "R10 read past table", g);
    chk("R10 past table zero", g, 32'h0);
    access(1, 5'h00, 4'hF, 32'hFF, "R10 sel FF", g);
    access(0, 5'h10, 4'hF, 0, "R10 read FF", g);
    chk("R10 index FF zero", g, 32'h0);

    // R2 illegal offset and partial strobe
    access(1, 5'h04, 4'hF, 32'h0000_0007, "R2 bad offset write", g);
    access(0, 5'h00, 4'hF, 0, "R2 sel unchanged", g);
    chk("R2 sel after bad offset", g, 32'h0000_00FF);
    access(1, 5'h00, 4'hF, 32'h0, "R2 sel id", g);
    access(1, 5'h10, 4'h3, 32'h1100_0000, "R2 partial write", g);
    access(0, 5'h10, 4'hF, 0, "R2 id unchanged", g);
    chk("R2 id after partial", g, 32'hAB00_0000);
    access(0, 5'h08, 4'hF, 0, "R2 bad offset read", g);

    // R3 back-pressure
    @(negedge clk); rsp_ready = 1'b0;
    access(0, 5'h10, 4'hF, 0, "R3 stalled read", held);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R3 rsp held valid", {31'h0, rsp_valid}, 32'h1);
      chk("R3 rsp data stable", rsp_rdata, held);
      chk("R3 req_ready low", {31'h0, req_ready}, 32'h0);
    end
    req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h10; req_strb = 4'hF;
    req_wdata = 32'h7700_0000;
    repeat (2) @(negedge clk);
    chk("R3 write not taken while stalled", {24'h0, unit_id}, 32'h0000_00AB);
    rsp_ready = 1'b1;
    @(posedge clk);
    m_write(m_sel, 32'h7700_0000);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 new response valid", {31'h0, rsp_valid}, 32'h1);
    chk("R3 new response data", rsp_rdata, 32'h0);
    chk("R3 write landed", {24'h0, unit_id}, 32'h0000_0077);
    @(negedge clk);
    chk("R3 response drained", {31'h0, rsp_valid}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule